// File: doc/BRIEF.md
# Two-Wire Configuration Slave for Clock Output Enables

This block is a two-wire serial slave that holds the configuration bytes of a clock distribution device. It runs on a local system clock and oversamples the serial clock and data lines. It drives the data line only through an open-drain enable. A host uses it to switch individual clock output pairs and the two feedback outputs on or off, and to choose the input threshold level. The rest of the device reads these settings from the decoded output ports.

Two static straps set how the device is addressed. The address strap chooses between two 7-bit slave addresses. The chip-select strap fixes the two-bit code that every command byte must carry. Four transfer types are accepted: byte write, byte read, block write and block read. A byte operation reaches one register, whose index is given in the command byte. A block operation always starts at index 0 and steps upwards through the indices. Block writes carry a byte count ahead of the data. Block reads use a repeated start, and the slave returns its own count before the data.

Top module: `smb_cfg_slave`

## Requirements
- R1: The slave acknowledges address 1101001 when `addr_sel`=1 and address 1101110 when `addr_sel`=0. The address is sent MSB first and is followed by the read/write bit, with 1 meaning read. For any other address the slave never pulls the data line low during that transfer.
- R2: After reset, `thresh_sel`=00, `fb_en`=11 and `pair_en`=all ones. These values are register 22 = 0x0F and register 23 = 0xFF.
- R3: The outputs are decoded from register 22 (A) and register 23 (B) as follows. `thresh_sel`=A[7:6]. `fb_en[i]`=NOT A[4+i]. `pair_en[3:0]`=A[3:0]. `pair_en[11:4]`=B[7:0].
- R4: A byte write uses command bit 7=1, with bits 4:0 giving the register index. The data byte is acknowledged and then stored at that index. A byte read is the same command, then a repeated start and the address with read. The slave then returns the stored byte MSB first.
- R5: Command bits 6:5 must be 01 when `chip_sel`=0 and 10 when `chip_sel`=1. If they do not match, the command byte is not acknowledged and the rest of the transfer changes no register.
- R6: A block write uses command bit 7=0. It carries a count byte N, and then data bytes that are stored at indices 0, 1, 2 and upwards. Only the first N data bytes are acknowledged and stored. Any later data byte is not acknowledged and not stored.
- R7: A block read uses command bit 7=0, a repeated start and the address with read. The slave first returns a count of 24, then the bytes of indices 0, 1, 2 and upwards. It stops driving after the master does not acknowledge a byte.
- R8: Indices other than 22 and 23 read back as 0, and writes to them have no effect on any output.
- R9: A START or STOP that arrives partway through a byte ends the transfer without a write, so the outputs are unchanged. The next transfer then works normally.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock used to oversample the bus |
| rst_n | input | 1 | Active-low asynchronous reset |
| scl_i | input | 1 | Serial clock line |
| sda_i | input | 1 | Serial data line, as seen on the wire |
| sda_oe | output | 1 | 1 pulls the data line low |
| addr_sel | input | 1 | Strap that chooses the slave address |
| chip_sel | input | 1 | Strap that chooses the required command code |
| thresh_sel | output | 2 | Input threshold select, 00 = normal, higher codes give lower levels |
| fb_en | output | 2 | Enables for the two feedback outputs |
| pair_en | output | 12 | Enables for the twelve clock output pairs |

## Verification
A wrong state-machine state or bit count shows up on the data line within one byte time. Either an acknowledge appears where none is expected, or a returned byte is shifted by one bit. A bad index pointer or byte count shows up at the next stop. It appears as a wrong enable pattern on `pair_en` or `fb_en`, or as a block read that returns bytes in the wrong slots. A write that is committed too early can be seen once a transfer has been cut off in mid-byte, because the outputs would then differ from their earlier values.

// File: rtl/smb_cfg_pkg.sv
package smb_cfg_pkg;
    typedef enum logic [2:0] {
        ST_IDLE, ST_RX, ST_ACK, ST_TX, ST_RACK, ST_WAIT
    } st_e;

    typedef enum logic [1:0] {
        K_ADDR, K_CMD, K_COUNT, K_DATA
    } kind_e;

    typedef struct packed {
        st_e        st;
        kind_e      kind;
        logic [3:0] cnt;
        logic [7:0] sr;
        logic       ack;
        logic       oe;
        logic       blk;
        logic       first;
        logic       mack;
        logic [7:0] ptr;
        logic [7:0] rem;
    } fsm_t;
endpackage

// File: rtl/smb_sync.sv
module smb_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic scl_i,
    input  logic sda_i,
    output logic scl_s,
    output logic sda_s,
    output logic scl_rise,
    output logic scl_fall,
    output logic bus_start,
    output logic bus_stop
);
    typedef struct packed {
        logic [STAGES-1:0] scl;
        logic [STAGES-1:0] sda;
        logic              scl_p;
        logic              sda_p;
    } sy_t;

    sy_t d, q;

    always_comb begin
        d       = q;
        d.scl   = {q.scl[STAGES-2:0], scl_i};
        d.sda   = {q.sda[STAGES-2:0], sda_i};
        d.scl_p = q.scl[STAGES-1];
        d.sda_p = q.sda[STAGES-1];
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) q <= '1;
        else        q <= d;
    end

    assign scl_s     = q.scl[STAGES-1];
    assign sda_s     = q.sda[STAGES-1];
    assign scl_rise  = scl_s & ~q.scl_p;
    assign scl_fall  = ~scl_s & q.scl_p;
    assign bus_start = scl_s & q.scl_p & q.sda_p & ~sda_s;
    assign bus_stop  = scl_s & q.scl_p & ~q.sda_p & sda_s;
endmodule

// File: rtl/smb_cfg_regs.sv
module smb_cfg_regs #(
    parameter int         IDX_A = 22,
    parameter int         IDX_B = 23,
    parameter logic [7:0] RST_A = 8'h0F,
    parameter logic [7:0] RST_B = 8'hFF
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       we,
    input  logic [7:0] idx,
    input  logic [7:0] wdata,
    output logic [7:0] rdata,
    output logic [7:0] reg_a,
    output logic [7:0] reg_b
);
    localparam logic [7:0] SLOT_A = 8'(IDX_A);
    localparam logic [7:0] SLOT_B = 8'(IDX_B);

    logic [7:0] a_d, a_q, b_d, b_q;
    logic       hit;

    always_comb begin
        a_d = a_q;
        b_d = b_q;
        if (we && idx == SLOT_A) a_d = wdata;
        if (we && idx == SLOT_B) b_d = wdata;
        hit = (idx == SLOT_A) || (idx == SLOT_B);
        if (idx == SLOT_A)      rdata = a_q;
        else if (idx == SLOT_B) rdata = b_q;
        else                    rdata = 8'h00;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            a_q <= RST_A;
            b_q <= RST_B;
        end else begin
            a_q <= a_d;
            b_q <= b_d;
        end
    end

    assign reg_a = a_q;
    assign reg_b = b_q;

    // R8: a write to an unimplemented slot leaves both stored bytes alone
    p_reserved_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (we && !hit) |=> ($stable(a_q) && $stable(b_q)));
endmodule

// File: rtl/smb_cfg_slave.sv
module smb_cfg_slave
    import smb_cfg_pkg::*;
#(
    parameter logic [6:0] ADDR_HI     = 7'b1101001,
    parameter logic [6:0] ADDR_LO     = 7'b1101110,
    parameter int         NUM_REGS    = 24,
    parameter int         IDX_A       = 22,
    parameter int         IDX_B       = 23,
    parameter logic [7:0] RST_A       = 8'h0F,
    parameter logic [7:0] RST_B       = 8'hFF,
    parameter int         SYNC_STAGES = 2
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        scl_i,
    input  logic        sda_i,
    output logic        sda_oe,
    input  logic        addr_sel,
    input  logic        chip_sel,
    output logic [1:0]  thresh_sel,
    output logic [1:0]  fb_en,
    output logic [11:0] pair_en
);
    localparam logic [7:0] COUNT_BYTE = 8'(NUM_REGS);

    logic scl_s, sda_s, scl_rise, scl_fall, bus_start, bus_stop;
    logic wr_en;
    logic [7:0] rdata, reg_a, reg_b, tx_byte;
    logic addr_ok, cs_ok, tx_count;
    fsm_t d, q;

    smb_sync #(.STAGES(SYNC_STAGES)) u_sync (
        .clk(clk), .rst_n(rst_n), .scl_i(scl_i), .sda_i(sda_i),
        .scl_s(scl_s), .sda_s(sda_s), .scl_rise(scl_rise), .scl_fall(scl_fall),
        .bus_start(bus_start), .bus_stop(bus_stop)
    );

    smb_cfg_regs #(.IDX_A(IDX_A), .IDX_B(IDX_B), .RST_A(RST_A), .RST_B(RST_B)) u_regs (
        .clk(clk), .rst_n(rst_n), .we(wr_en), .idx(q.ptr), .wdata(q.sr),
        .rdata(rdata), .reg_a(reg_a), .reg_b(reg_b)
    );

    always_comb begin
        d        = q;
        wr_en    = 1'b0;
        addr_ok  = (q.sr[7:1] == (addr_sel ? ADDR_HI : ADDR_LO));
        cs_ok    = (q.sr[6:5] == (chip_sel ? 2'b10 : 2'b01));
        tx_count = q.blk && q.first;
        tx_byte  = tx_count ? COUNT_BYTE : rdata;
        if (bus_start) begin
            d.st   = ST_RX;
            d.kind = K_ADDR;
            d.cnt  = '0;
            d.oe   = 1'b0;
        end else if (bus_stop) begin
            d.st = ST_IDLE;
            d.oe = 1'b0;
        end else begin
            case (q.st)
                ST_RX: begin
                    if (scl_rise && q.cnt < 4'd8) begin
                        d.sr  = {q.sr[6:0], sda_s};
                        d.cnt = q.cnt + 4'd1;
                    end else if (scl_fall && q.cnt == 4'd8) begin
                        d.cnt = '0;
                        d.st  = ST_ACK;
                        case (q.kind)
                            K_ADDR:  d.ack = addr_ok;
                            K_CMD:   d.ack = cs_ok;
                            K_COUNT: d.ack = 1'b1;
                            default: d.ack = (q.rem != 8'd0);
                        endcase
                        d.oe = d.ack;
                    end
                end
                ST_ACK: begin
                    if (scl_fall) begin
                        d.oe = 1'b0;
                        if (!q.ack) begin
                            d.st = ST_WAIT;
                        end else begin
                            case (q.kind)
                                K_ADDR: begin
                                    if (q.sr[0]) begin
                                        d.st    = ST_TX;
                                        d.sr    = tx_byte;
                                        d.first = 1'b0;
                                        if (!tx_count) d.ptr = q.ptr + 8'd1;
                                        d.oe    = ~tx_byte[7];
                                    end else begin
                                        d.st   = ST_RX;
                                        d.kind = K_CMD;
                                    end
                                end
                                K_CMD: begin
                                    d.st    = ST_RX;
                                    d.blk   = ~q.sr[7];
                                    d.first = 1'b1;
                                    d.ptr   = q.sr[7] ? {3'b000, q.sr[4:0]} : 8'd0;
                                    d.rem   = 8'd1;
                                    d.kind  = q.sr[7] ? K_DATA : K_COUNT;
                                end
                                K_COUNT: begin
                                    d.st    = ST_RX;
                                    d.rem   = q.sr;
                                    d.first = 1'b0;
                                    d.kind  = K_DATA;
                                end
                                default: begin
                                    wr_en = 1'b1;
                                    d.st  = ST_RX;
                                    d.ptr = q.ptr + 8'd1;
                                    d.rem = q.rem - 8'd1;
                                end
                            endcase
                        end
                    end
                end
                ST_TX: begin
                    if (scl_fall) begin
                        if (q.cnt == 4'd7) begin
                            d.st  = ST_RACK;
                            d.cnt = '0;
                            d.oe  = 1'b0;
                        end else begin
                            d.sr  = {q.sr[6:0], 1'b0};
                            d.cnt = q.cnt + 4'd1;
                            d.oe  = ~q.sr[6];
                        end
                    end
                end
                ST_RACK: begin
                    if (scl_rise) begin
                        d.mack = sda_s;
                    end else if (scl_fall) begin
                        if (!q.mack) begin
                            d.st    = ST_TX;
                            d.sr    = tx_byte;
                            d.first = 1'b0;
                            if (!tx_count) d.ptr = q.ptr + 8'd1;
                            d.oe    = ~tx_byte[7];
                        end else begin
                            d.st = ST_WAIT;
                        end
                    end
                end
                default: ;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            q       <= '0;
            q.st    <= ST_IDLE;
            q.kind  <= K_ADDR;
            q.blk   <= 1'b1;
            q.first <= 1'b1;
            q.mack  <= 1'b1;
        end else begin
            q <= d;
        end
    end

    assign sda_oe     = q.oe;
    assign thresh_sel = reg_a[7:6];
    assign fb_en      = ~reg_a[5:4];
    assign pair_en    = {reg_b, reg_a[3:0]};

    // R1: the data line is only pulled or released while the clock is low
    p_oe_scl_low_r1: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(q.oe) |-> (!scl_s || bus_start || bus_stop));
    // R1: an address acknowledge is only given for a matching address
    p_addr_ack_r1: assert property (@(posedge clk) disable iff (!rst_n)
        (q.st == ST_ACK && q.kind == K_ADDR && q.oe) |-> addr_ok);
    // R5: a command acknowledge requires the chip-select code
    p_cs_gate_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (q.st == ST_ACK && q.kind == K_CMD && q.oe) |-> cs_ok);
    // R6: no store once the byte budget is used up
    p_count_limit_r6: assert property (@(posedge clk) disable iff (!rst_n)
        wr_en |-> (q.rem != 8'd0));
    // R9: stores happen only at the clock fall that ends the acknowledge
    p_wr_after_ack_r9: assert property (@(posedge clk) disable iff (!rst_n)
        wr_en |-> (q.st == ST_ACK && q.ack && scl_fall));
    // R4: bit counter never runs past a full byte
    p_cnt_range_r4: assert property (@(posedge clk) disable iff (!rst_n)
        q.cnt <= 4'd8);
endmodule

// File: tb/test_smb_cfg_slave.sv
module test_smb_cfg_slave;
    localparam int Q = 8;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic scl_m = 1'b1;
    logic m_low = 1'b0;
    logic addr_sel = 1'b1;
    logic chip_sel = 1'b0;
    logic sda_oe;
    logic [1:0] thresh_sel, fb_en;
    logic [11:0] pair_en;
    logic sda_line;

    int n_checks = 0;
    int n_fail = 0;
    logic [7:0] m22 = 8'h0F;
    logic [7:0] m23 = 8'hFF;
    logic [7:0] zero_bytes [24];

    always #2.5 clk = ~clk;
    assign sda_line = ~(sda_oe | m_low);

    smb_cfg_slave i_smb_cfg_slave (
        .clk(clk), .rst_n(rst_n), .scl_i(scl_m), .sda_i(sda_line), .sda_oe(sda_oe),
        .addr_sel(addr_sel), .chip_sel(chip_sel),
        .thresh_sel(thresh_sel), .fb_en(fb_en), .pair_en(pair_en)
    );

    // {index, write data, expected read-back}
    localparam logic [23:0] VEC [6] = '{
        {8'd22, 8'hA5, 8'hA5},
        {8'd23, 8'h3C, 8'h3C},
        {8'd5,  8'h77, 8'h00},
        {8'd22, 8'h5A, 8'h5A},
        {8'd31, 8'hFF, 8'h00},
        {8'd23, 8'hC3, 8'hC3}
    };

    task automatic wt(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic check(input string tag, input int got, input int exp);
        n_checks++;
        if (got != exp) begin
            n_fail++;
            $display("FAIL %s: got %0h expected %0h", tag, got, exp);
        end
    endtask

    task automatic summary;
        $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
        $finish;
    endtask

    task automatic check_outs(input string tag);
        check(tag, {thresh_sel, fb_en, pair_en},
              {m22[7:6], ~m22[5:4], m23, m22[3:0]});
    endtask

    task automatic b_start;
        m_low = 1'b0; wt(Q); scl_m = 1'b1; wt(Q);
        m_low = 1'b1; wt(Q); scl_m = 1'b0; wt(Q);
    endtask

    task automatic b_stop;
        m_low = 1'b1; wt(Q); scl_m = 1'b1; wt(Q);
        m_low = 1'b0; wt(Q);
    endtask

    task automatic send_bit(input logic b);
        m_low = ~b; wt(Q); scl_m = 1'b1; wt(2 * Q); scl_m = 1'b0; wt(Q);
    endtask

    task automatic send_byte(input logic [7:0] v, output logic ack);
        for (int i = 7; i >= 0; i--) send_bit(v[i]);
        m_low = 1'b0; wt(Q); scl_m = 1'b1; wt(Q);
        ack = ~sda_line;
        wt(Q); scl_m = 1'b0; wt(Q);
    endtask

    task automatic recv_byte(input logic give_ack, output logic [7:0] v);
        for (int i = 7; i >= 0; i--) begin
            m_low = 1'b0; wt(Q); scl_m = 1'b1; wt(Q);
            v[i] = sda_line;
            wt(Q); scl_m = 1'b0; wt(Q);
        end
        m_low = give_ack; wt(Q); scl_m = 1'b1; wt(2 * Q); scl_m = 1'b0; wt(Q);
        m_low = 1'b0;
    endtask

    function automatic logic [7:0] byte_cmd(input logic [4:0] idx);
        return {1'b1, (chip_sel ? 2'b10 : 2'b01), idx};
    endfunction

    function automatic logic [7:0] blk_cmd();
        return {1'b0, (chip_sel ? 2'b10 : 2'b01), 5'd0};
    endfunction

    function automatic logic [7:0] adr(input logic rd);
        return {(addr_sel ? 7'b1101001 : 7'b1101110), rd};
    endfunction

    task automatic byte_write(input logic [4:0] idx, input logic [7:0] v, output logic all_ack);
        logic a0, a1, a2;
        b_start;
        send_byte(adr(1'b0), a0);
        send_byte(byte_cmd(idx), a1);
        send_byte(v, a2);
        b_stop;
        all_ack = a0 & a1 & a2;
    endtask

    task automatic byte_read(input logic [4:0] idx, output logic [7:0] v);
        logic a;
        b_start;
        send_byte(adr(1'b0), a);
        send_byte(byte_cmd(idx), a);
        b_start;
        send_byte(adr(1'b1), a);
        recv_byte(1'b0, v);
        b_stop;
    endtask

    initial begin
        wt(150000);
        n_checks++;
        n_fail++;
        $display("FAIL watchdog: got timeout expected completion");
        summary;
    end

    initial begin
        logic ack, a2;
        logic [7:0] v;
        logic [7:0] lo, hi;
        int cnt_bad;
        wt(5);
        check("R2 sda released in reset", sda_oe, 0);
        rst_n = 1'b1;
        wt(10);
        check("R2 reset outputs", {thresh_sel, fb_en, pair_en}, {2'b00, 2'b11, 12'hFFF});

        // R3 R4 R8: table of byte writes, then read-back and output decode
        for (int k = 0; k < 6; k++) begin
            logic [7:0] ix, wd, ex;
            {ix, wd, ex} = VEC[k];
            byte_write(ix[4:0], wd, ack);
            if (ix == 8'd22) m22 = wd;
            if (ix == 8'd23) m23 = wd;
            check("R4 byte write acknowledged", ack, 1);
            check("R3 R8 outputs after byte write", {thresh_sel, fb_en, pair_en},
                  {m22[7:6], ~m22[5:4], m23, m22[3:0]});
            byte_read(ix[4:0], v);
            check("R4 R8 byte read-back", v, ex);
        end

        // R1: wrong address and the other strap value
        b_start; send_byte(8'hD4, ack); b_stop;
        check("R1 foreign address not acknowledged", ack, 0);
        addr_sel = 1'b0;
        b_start; send_byte(8'hD2, ack); b_stop;
        check("R1 high-strap address ignored when strap low", ack, 0);
        byte_write(5'd22, 8'h30, ack);
        m22 = 8'h30;
        check("R1 low-strap address acknowledged", ack, 1);
        check_outs("R1 R3 write through low-strap address");
        addr_sel = 1'b1;

        // R5: command code mismatch
        b_start;
        send_byte(adr(1'b0), ack);
        send_byte(8'hD6, ack);
        send_byte(8'h00, a2);
        b_stop;
        check("R5 mismatched chip-select code not acknowledged", ack, 0);
        check("R5 data after bad command not acknowledged", a2, 0);
        check_outs("R5 outputs unchanged after bad command");
        chip_sel = 1'b1;
        byte_write(5'd23, 8'h0F, ack);
        m23 = 8'h0F;
        check("R5 high chip-select code accepted", ack, 1);
        check_outs("R5 outputs after high chip-select write");
        chip_sel = 1'b0;

        // R6: full block write of 24 bytes, then one extra
        b_start;
        send_byte(adr(1'b0), ack);
        send_byte(blk_cmd(), ack);
        send_byte(8'd24, ack);
        cnt_bad = 0;
        for (int i = 0; i < 24; i++) begin
            send_byte((i == 22) ? 8'h4B : (i == 23) ? 8'h81 : 8'h00, ack);
            if (!ack) cnt_bad++;
        end
        send_byte(8'hEE, a2);
        b_stop;
        m22 = 8'h4B; m23 = 8'h81;
        check("R6 all counted bytes acknowledged", cnt_bad, 0);
        check("R6 byte beyond count not acknowledged", a2, 0);
        check_outs("R6 outputs after block write");

        // R6: count 23 stops short of index 23
        b_start;
        send_byte(adr(1'b0), ack);
        send_byte(blk_cmd(), ack);
        send_byte(8'd23, ack);
        for (int i = 0; i < 23; i++) send_byte((i == 22) ? 8'hC0 : 8'h00, ack);
        send_byte(8'h55, a2);
        b_stop;
        m22 = 8'hC0;
        check("R6 24th byte refused under count 23", a2, 0);
        check_outs("R6 index 23 untouched under count 23");

        // R7: block read
        b_start;
        send_byte(adr(1'b0), ack);
        send_byte(blk_cmd(), ack);
        b_start;
        send_byte(adr(1'b1), ack);
        check("R7 read address acknowledged", ack, 1);
        recv_byte(1'b1, v);
        check("R7 count byte", v, 24);
        cnt_bad = 0;
        lo = 8'h00; hi = 8'h00;
        for (int i = 0; i < 24; i++) begin
            recv_byte(i != 23, v);
            if (i == 22) lo = v;
            else if (i == 23) hi = v;
            else if (v != 8'h00) cnt_bad++;
        end
        check("R7 slave idle after final NACK", sda_oe, 0);
        b_stop;
        check("R7 R8 reserved bytes read zero", cnt_bad, 0);
        check("R7 index 22 in order", lo, m22);
        check("R7 index 23 in order", hi, m23);

        // R9: stop in the middle of a data byte
        b_start;
        send_byte(adr(1'b0), ack);
        send_byte(byte_cmd(5'd22), ack);
        for (int i = 0; i < 4; i++) send_bit(1'b1);
        b_stop;
        check_outs("R9 partial byte then stop leaves outputs");
        // R9: repeated start in the middle of a data byte
        b_start;
        send_byte(adr(1'b0), ack);
        send_byte(byte_cmd(5'd23), ack);
        for (int i = 0; i < 5; i++) send_bit(1'b0);
        b_start;
        send_byte(adr(1'b0), ack);
        b_stop;
        check("R9 address after mid-byte start acknowledged", ack, 1);
        check_outs("R9 partial byte then start leaves outputs");
        byte_write(5'd22, 8'h0F, ack);
        m22 = 8'h0F;
        check("R9 recovery write acknowledged", ack, 1);
        check_outs("R9 outputs after recovery write");

        summary;
    end
endmodule